// File: doc/BRIEF.md
# Backend Stage Stall and Squash Controller

This block governs the flow status of one stage in an out-of-order backend, sitting between an earlier renaming stage and a later retirement (commit) stage. Every cycle it decides whether the incoming instruction group from rename goes straight on to dispatch, gets parked in a small skid buffer, or is discarded. It can do this because it tracks five statuses: idle, running, blocked, draining the skid buffer, and squashing.

When commit asks the stage to hold, or the instruction queue reports it is full, the stage blocks. In the blocked state it captures every arriving group into the skid buffer, oldest first, and keeps stall asserted back to rename. Once the hold clears, the buffer is drained one group per cycle in arrival order, before normal running resumes. A squash request from commit overrides both running and blocking. It empties the skid buffer and keeps the stage squashing until both squash flags drop. At that point it sends a one-cycle stop pulse to the instruction queue. Independently of all this, the queue's free-entry count is forwarded to rename one cycle late.

Top module: `stage_status_ctrl`

## Requirements
- R1: While reset is asserted and on release, the status code is 0 (idle) and `stall_to_rename`, `disp_valid`, `stop_squash`, `skid_overflow` and `free_to_rename` are all 0. Status codes are 0 idle, 1 running, 2 blocked, 3 draining, 4 squashing.
- R2: In idle, a cycle with `rn_valid` high and no commit request and `iq_full` low dispatches that group and moves to running. Without a valid group, the stage stays idle.
- R3: In idle, running or draining, a high `cm_stall` has priority over everything. There is no dispatch that cycle, a valid group present is captured into the skid buffer, and the next status is blocked. In running with no commit request, a valid group is dispatched the same cycle (`disp_group` equals `rn_group`).
- R4: In idle, running or draining, with `cm_stall` low, either `cm_squash` or `cm_rob_squash` high sends the next status to squashing. There is no dispatch that cycle.
- R5: In idle or running with no commit request, a valid group arriving while `iq_full` is high is not dispatched. It is captured, `stall_to_rename` is high that cycle, and the next status is blocked.
- R6: In blocked, `stall_to_rename` is high every cycle and every valid group is captured. A squash flag takes the stage to squashing. Otherwise, with `cm_stall` and `iq_full` both low, the stage leaves for draining if the buffer will hold any group, and for running if not.
- R7: In draining, one buffered group is output on `disp_group` with `disp_valid` each cycle, oldest first. `stall_to_rename` stays high, valid incoming groups are appended behind the buffered ones, and the stage becomes running once the buffer is empty.
- R8: In squashing, there is no dispatch, stall is low and incoming groups are dropped. When both squash flags are low, `stop_squash` is high for that cycle and the next status is running.
- R9: Entering squashing empties the skid buffer, so no group captured before a squash is ever replayed.
- R10: A capture attempted while the buffer already holds SKID_DEPTH groups, with no pop in the same cycle, raises `skid_overflow` for that cycle and drops the group.
- R11: `free_to_rename` equals the `iq_free` value of the previous cycle, in every status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rn_valid | input | 1 | Incoming rename group is valid |
| rn_group | input | GROUP_W | Incoming rename group payload |
| cm_stall | input | 1 | Hold request from commit |
| cm_squash | input | 1 | Squash request from commit |
| cm_rob_squash | input | 1 | Reorder buffer is squashing |
| iq_full | input | 1 | Instruction queue is full |
| iq_free | input | FREE_W | Free entries in the instruction queue |
| stall_to_rename | output | 1 | Stall back to the rename stage |
| free_to_rename | output | FREE_W | Registered free-entry count for rename |
| disp_valid | output | 1 | A group is dispatched this cycle |
| disp_group | output | GROUP_W | Dispatched group (live or replayed) |
| stop_squash | output | 1 | One-cycle end-of-squash pulse to the queue |
| skid_overflow | output | 1 | Capture attempted into a full skid buffer |
| stage_state | output | 3 | Current status code |

## Verification
Random traffic mixes rare commit holds and squashes with frequent valid groups and an often-full queue. This exercises priority between hold, squash and queue-full in each status, and a bench model predicts every output. Directed runs fill the buffer past its depth and then release it. That separates correct drop-on-overflow and oldest-first replay from a buffer that overwrites or reorders. A block, squash, block-again sequence shows whether a stale group survives the squash flush. Idle cycles without valid groups show that the stage does not leave idle by itself.

// File: rtl/stage_ctl_pkg.sv
package stage_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_BLOCK  = 3'd2,
    ST_UNBLK  = 3'd3,
    ST_SQUASH = 3'd4
  } stage_state_e;

  // Statuses in which the stage would normally try to dispatch.
  function automatic logic on_run_path(stage_state_e s);
    return (s == ST_IDLE) || (s == ST_RUN) || (s == ST_UNBLK);
  endfunction

endpackage

// File: rtl/stage_skid_fifo.sv
module stage_skid_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic                         flush,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         drop
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] fill_next(logic [CNT_W-1:0] c,
                                                  logic inc, logic dec);
    return c + CNT_W'(inc) - CNT_W'(dec);
  endfunction

  logic push_ok, pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign drop    = push && full && !pop_ok;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      count <= fill_next(count, push_ok, pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= din;
  end

  // R10: the fill level never exceeds the depth
  p_fill_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R10: a dropped capture leaves the fill level unchanged
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !flush) |=> count == $past(count));

endmodule

// File: rtl/stage_status_fsm.sv
module stage_status_fsm
  import stage_ctl_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  stage_state_e      state_q,
  input  logic              in_valid,
  input  logic              cmt_stall,
  input  logic              sq_any,
  input  logic              iq_full,
  input  logic [CNT_W-1:0]  skid_count,
  input  logic              skid_empty,
  output stage_state_e      state_d,
  output logic              push,
  output logic              pop,
  output logic              flush,
  output logic              disp_live,
  output logic              disp_replay,
  output logic              stall_up,
  output logic              stop_sq
);

  // Buffer runs dry after this cycle's pop when only one group remains
  // and nothing new is appended.
  function automatic logic drains_now(logic [CNT_W-1:0] c, logic add);
    return (c == CNT_W'(1)) && !add;
  endfunction

  always_comb begin
    state_d     = state_q;
    push        = 1'b0;
    pop         = 1'b0;
    flush       = 1'b0;
    disp_live   = 1'b0;
    disp_replay = 1'b0;
    stall_up    = 1'b0;
    stop_sq     = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_RUN, ST_UNBLK: begin
        stall_up = (state_q == ST_UNBLK);
        if (cmt_stall) begin
          push    = in_valid;
          state_d = ST_BLOCK;
        end else if (sq_any) begin
          flush   = 1'b1;
          state_d = ST_SQUASH;
        end else if (state_q == ST_UNBLK) begin
          pop         = 1'b1;
          disp_replay = 1'b1;
          push        = in_valid;
          state_d     = drains_now(skid_count, in_valid) ? ST_RUN : ST_UNBLK;
        end else if (in_valid) begin
          if (iq_full) begin
            push     = 1'b1;
            stall_up = 1'b1;
            state_d  = ST_BLOCK;
          end else begin
            disp_live = 1'b1;
            state_d   = ST_RUN;
          end
        end
      end
      ST_BLOCK: begin
        stall_up = 1'b1;
        if (sq_any) begin
          flush   = 1'b1;
          state_d = ST_SQUASH;
        end else begin
          push = in_valid;
          if (!cmt_stall && !iq_full)
            state_d = (!skid_empty || in_valid) ? ST_UNBLK : ST_RUN;
        end
      end
      ST_SQUASH: begin
        if (!sq_any) begin
          stop_sq = 1'b1;
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/stage_status_ctrl.sv
module stage_status_ctrl
  import stage_ctl_pkg::*;
#(
  parameter int GROUP_W    = 16,
  parameter int SKID_DEPTH = 4,
  parameter int FREE_W     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rn_valid,
  input  logic [GROUP_W-1:0]  rn_group,
  input  logic                cm_stall,
  input  logic                cm_squash,
  input  logic                cm_rob_squash,
  input  logic                iq_full,
  input  logic [FREE_W-1:0]   iq_free,
  output logic                stall_to_rename,
  output logic [FREE_W-1:0]   free_to_rename,
  output logic                disp_valid,
  output logic [GROUP_W-1:0]  disp_group,
  output logic                stop_squash,
  output logic                skid_overflow,
  output logic [2:0]          stage_state
);
  localparam int CNT_W = $clog2(SKID_DEPTH + 1);

  stage_state_e state_q, state_d;
  logic sq_any;
  logic push, pop, flush, disp_live, disp_replay;
  logic [GROUP_W-1:0] skid_head;
  logic [CNT_W-1:0]   skid_count;
  logic skid_full, skid_empty, skid_drop;

  assign sq_any = cm_squash || cm_rob_squash;

  stage_status_fsm #(.CNT_W(CNT_W)) u_fsm (
    .state_q     (state_q),
    .in_valid    (rn_valid),
    .cmt_stall   (cm_stall),
    .sq_any      (sq_any),
    .iq_full     (iq_full),
    .skid_count  (skid_count),
    .skid_empty  (skid_empty),
    .state_d     (state_d),
    .push        (push),
    .pop         (pop),
    .flush       (flush),
    .disp_live   (disp_live),
    .disp_replay (disp_replay),
    .stall_up    (stall_to_rename),
    .stop_sq     (stop_squash)
  );

  stage_skid_fifo #(.W(GROUP_W), .DEPTH(SKID_DEPTH)) u_skid (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .flush (flush),
    .din   (rn_group),
    .head  (skid_head),
    .count (skid_count),
    .full  (skid_full),
    .empty (skid_empty),
    .drop  (skid_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      free_to_rename <= '0;
    end else begin
      state_q        <= state_d;
      free_to_rename <= iq_free;
    end
  end

  assign disp_valid    = disp_live || disp_replay;
  assign disp_group    = disp_replay ? skid_head : rn_group;
  assign skid_overflow = skid_drop;
  assign stage_state   = state_q;

  // R6: blocked always holds rename
  p_block_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLOCK) |-> stall_to_rename);

  // R7: draining keeps rename held
  p_drain_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UNBLK) |-> stall_to_rename);

  // R3: commit hold on the run path leads to blocked
  p_hold_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (on_run_path(state_q) && cm_stall) |=> (state_q == ST_BLOCK));

  // R8: leaving squash returns to running with a stop pulse
  p_squash_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SQUASH && !cm_squash && !cm_rob_squash)
      |-> stop_squash ##1 (state_q == ST_RUN));

  // R9: the skid buffer is empty throughout squashing
  p_squash_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SQUASH) |-> (skid_count == '0));

  // R11: the free count follows the queue input one cycle later
  p_free_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (free_to_rename == $past(iq_free)));

endmodule

// File: tb/stage_status_ctrl_bench.sv
`timescale 1ns/1ps
module stage_status_ctrl_bench;
  localparam int GW = 16;
  localparam int DEPTH = 4;
  localparam int FW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rn_valid = 0, cm_stall = 0, cm_squash = 0, cm_rob_squash = 0, iq_full = 0;
  logic [GW-1:0] rn_group = '0;
  logic [FW-1:0] iq_free = '0;
  logic stall_to_rename, disp_valid, stop_squash, skid_overflow;
  logic [FW-1:0] free_to_rename;
  logic [GW-1:0] disp_group;
  logic [2:0] stage_state;

  always #10 clk = ~clk;

  stage_status_ctrl #(.GROUP_W(GW), .SKID_DEPTH(DEPTH), .FREE_W(FW)) u_stage_status_ctrl (
    .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_group(rn_group),
    .cm_stall(cm_stall), .cm_squash(cm_squash), .cm_rob_squash(cm_rob_squash),
    .iq_full(iq_full), .iq_free(iq_free), .stall_to_rename(stall_to_rename),
    .free_to_rename(free_to_rename), .disp_valid(disp_valid), .disp_group(disp_group),
    .stop_squash(stop_squash), .skid_overflow(skid_overflow), .stage_state(stage_state));

  int checks = 0, fails = 0;
  bit done = 0;

  // Bench model
  int m_st;
  logic [GW-1:0] mq[$];
  logic [FW-1:0] m_prev_free;
  // Expected combinational outputs and next-cycle effects
  bit e_stall, e_dv, e_stop, e_ovf, e_push, e_pop, e_flush;
  logic [GW-1:0] e_grp;
  int e_next;
  string tag;

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (time %0t)", t, what, act, exp, $time);
    end
  endtask

  task automatic eval_model();
    bit sq = cm_squash || cm_rob_squash;
    e_stall = 0; e_dv = 0; e_stop = 0; e_ovf = 0;
    e_push = 0; e_pop = 0; e_flush = 0; e_grp = rn_group; e_next = m_st;
    if (m_st == 0 || m_st == 1 || m_st == 3) begin
      e_stall = (m_st == 3);
      if (cm_stall) begin
        tag = "R3"; e_push = rn_valid; e_next = 2;
      end else if (sq) begin
        tag = "R4"; e_flush = 1; e_next = 4;
      end else if (m_st == 3) begin
        tag = "R7"; e_pop = 1; e_dv = 1; e_grp = mq[0]; e_push = rn_valid;
        e_next = (mq.size() == 1 && !rn_valid) ? 1 : 3;
      end else if (rn_valid) begin
        if (iq_full) begin
          tag = "R5"; e_push = 1; e_stall = 1; e_next = 2;
        end else begin
          tag = (m_st == 0) ? "R2" : "R3"; e_dv = 1; e_next = 1;
        end
      end else tag = (m_st == 0) ? "R2" : "R3";
    end else if (m_st == 2) begin
      tag = "R6"; e_stall = 1;
      if (sq) begin e_flush = 1; e_next = 4; end
      else begin
        e_push = rn_valid;
        if (!cm_stall && !iq_full) e_next = (mq.size() > 0 || rn_valid) ? 3 : 1;
      end
    end else begin
      tag = "R8";
      if (!sq) begin e_stop = 1; e_next = 1; end
    end
    e_ovf = e_push && !e_pop && (mq.size() == DEPTH);
  endtask

  task automatic update_model();
    if (e_flush) mq.delete();
    else begin
      if (e_pop && mq.size() > 0) void'(mq.pop_front());
      if (e_push && !e_ovf) mq.push_back(rn_group);
    end
    m_st = e_next;
    m_prev_free = iq_free;
  endtask

  // Entered just after a rising edge; checks before the next one.
  task automatic cyc(bit v, logic [GW-1:0] g, bit st, bit sq, bit rob, bit full,
                     logic [FW-1:0] fr);
    rn_valid = v; rn_group = g; cm_stall = st; cm_squash = sq;
    cm_rob_squash = rob; iq_full = full; iq_free = fr;
    #8;
    eval_model();
    chk(tag, "state", stage_state, m_st);
    chk(tag, "stall_to_rename", stall_to_rename, e_stall);
    chk(tag, "disp_valid", disp_valid, e_dv);
    if (e_dv) chk(tag, "disp_group", disp_group, e_grp);
    chk("R8", "stop_squash", stop_squash, e_stop);
    chk("R10", "skid_overflow", skid_overflow, e_ovf);
    chk("R11", "free_to_rename", free_to_rename, m_prev_free);
    update_model();
    @(posedge clk); #2;
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'h5eed);
    m_st = 0; m_prev_free = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1", "state", stage_state, 0);
    chk("R1", "stall_to_rename", stall_to_rename, 0);
    chk("R1", "disp_valid", disp_valid, 0);
    chk("R1", "stop_squash", stop_squash, 0);
    chk("R1", "skid_overflow", skid_overflow, 0);
    chk("R1", "free_to_rename", free_to_rename, 0);
    rst_n = 1;
    chk("R1", "state after release", stage_state, 0);

    // R2: no valid group keeps idle, then first group starts running
    repeat (3) cyc(0, 16'h0, 0, 0, 0, 0, 6'd5);
    cyc(1, 16'h1111, 0, 0, 0, 0, 6'd7);
    cyc(1, 16'h2222, 0, 0, 0, 0, 6'd9);

    // R10 and R7: overfill under commit hold, then oldest-first drain
    for (int i = 0; i < 6; i++) cyc(1, 16'hA0 + 16'(i), 1, 0, 0, 0, 6'(i));
    cyc(0, 16'h0, 0, 0, 0, 1, 6'd3);
    for (int i = 0; i < 5; i++) cyc(0, 16'h0, 0, 0, 0, 0, 6'd4);

    // R5: queue-full block, drain with an appended group
    cyc(1, 16'hB0, 0, 0, 0, 1, 6'd0);
    cyc(1, 16'hB1, 0, 0, 0, 0, 6'd2);
    cyc(1, 16'hB2, 0, 0, 0, 0, 6'd2);
    repeat (3) cyc(0, 16'h0, 0, 0, 0, 0, 6'd2);

    // R9: capture, squash, capture again; replay must show only the new group
    cyc(1, 16'hC0, 1, 0, 0, 0, 6'd1);
    cyc(1, 16'hC1, 0, 1, 0, 0, 6'd1);
    cyc(0, 16'h0, 0, 0, 1, 0, 6'd1);
    cyc(0, 16'h0, 0, 0, 0, 0, 6'd1);
    cyc(1, 16'hC2, 1, 0, 0, 0, 6'd1);
    cyc(0, 16'h0, 0, 0, 0, 0, 6'd1);
    #8;
    chk("R9", "replayed group after squash", disp_group, 16'hC2);
    chk("R9", "replay valid", disp_valid, 1);
    @(posedge clk); #2;
    // the check above consumed a cycle without the model; resync
    eval_model(); update_model();
    repeat (2) cyc(0, 16'h0, 0, 0, 0, 0, 6'd1);

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      bit v  = ($urandom_range(0, 9) < 7);
      bit st = ($urandom_range(0, 9) < 2);
      bit sq = ($urandom_range(0, 24) == 0);
      bit rb = ($urandom_range(0, 24) == 0);
      bit fl = ($urandom_range(0, 9) < 3);
      cyc(v, 16'($urandom), st, sq, rb, fl, 6'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule